// File: doc/BRIEF.md
# Link-Facing Register Bank for a ULPI Transceiver

This block is the bank of configuration and status bytes that a ULPI link reaches through the transceiver's register access commands. Bus framing is handled upstream: this block sees an already decoded access port with a 6-bit address, a write strobe with write data, and a read strobe with combinational read data. Every access is accepted in the cycle it is presented. There is no back-pressure, because each register answers in a single cycle. The block holds fixed identifier bytes, several control bytes that drive the rest of the transceiver, two edge-enable masks, a live view of the interrupt sources, a sticky interrupt latch and a debug byte.

Each writable byte occupies three consecutive addresses. The first address replaces the value. The second ORs the written data into it. The third clears every bit that is 1 in the written data. A read at any of the three addresses returns the same byte.

The interrupt sources enter as a vector, with bit 4 reserved for the ID-ground indication. Each source can latch an interrupt on a rising change, on a falling change, or on both, according to two separate enable masks. The latch register clears when it is read. An interrupt request output is high while any latched bit is set.

Top module: `ulpi_phy_regfile`

## Requirements
- R1: Addresses 00h, 01h, 02h and 03h read back, in that order, the low and high bytes of VENDOR_ID and then the low and high bytes of PRODUCT_ID. Writes to these addresses change nothing.
- R2: After reset, the writable bytes hold these values: function control (base 04h) 41h, interface control (base 07h) 00h, OTG control (base 0Ah) 06h, rising enable (base 0Dh) 1Fh, falling enable (base 10h) 1Fh, power control (base 3Dh) 00h. At the same time, irq is low.
- R3: A write to a writable byte's base address loads the write data, with its reserved bits forced to 0. The matching control output shows the new value from the next cycle.
- R4: A write to base+1 ORs the write data, restricted to the writable bits, into the byte.
- R5: A write to base+2 clears every bit of the byte that is 1 in the write data.
- R6: A read at base, base+1 or base+2 returns the same current byte.
- R7: Reserved bits always read 0. These are function control bit 7, enable bits 7:5 and power control bits 7:3.
- R8: Address 13h returns the interrupt source vector sampled at the previous clock edge. Address 15h returns line_state in bits 1:0 in the same cycle, with 0 in the other bits.
- R9: A latch bit at address 14h sets two cycles after its source rises, provided its rising-enable bit is 1. If that enable bit is 0, the rise sets nothing.
- R10: A latch bit sets two cycles after its source falls, provided its falling-enable bit is 1. If that enable bit is 0, the fall sets nothing.
- R11: A read of 14h returns the latch and clears it at the following edge. A new event arriving at that same edge is kept. Otherwise, a set bit holds.
- R12: irq is high exactly while any latch bit is set.
- R13: Addresses 16h to 3Ch read 00h, and writes to them leave every register unchanged.
- R14: reg_rdata is 00h whenever reg_rd is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 6 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 8 | Read data, combinational |
| irq_src | input | NUM_SRC | Interrupt source levels, bit 4 is ID-ground |
| line_state | input | LS_W | Line state shown in the debug byte |
| func_ctrl | output | 8 | Function control byte |
| intf_ctrl | output | 8 | Interface control byte |
| otg_ctrl | output | 8 | OTG control byte |
| pwr_ctrl | output | 8 | Power control byte |
| irq | output | 1 | Any latched interrupt pending |

## Verification
The bench builds the block with NUM_SRC of 5 and LS_W of 2. This puts the ID-ground source at bit 4, alongside lower sources that can fire together with it. The identifier parameters are set to four distinct byte values, so that a swapped or misordered identifier byte shows up in the read data. With five sources, the reset value of the enable masks covers every source, and the test can clear bits out of those masks one at a time.

// File: rtl/ulpi_rf_pkg.sv
package ulpi_rf_pkg;
  localparam int AW = 6;
  localparam int DW = 8;
  localparam int NUM_CTRL = 6;
  localparam int ALIAS_N = 3;

  localparam int CI_FUNC = 0;
  localparam int CI_INTF = 1;
  localparam int CI_OTG = 2;
  localparam int CI_IE_RISE = 3;
  localparam int CI_IE_FALL = 4;
  localparam int CI_PWR = 5;

  localparam logic [AW-1:0] A_VID_LO = 6'h00;
  localparam logic [AW-1:0] A_VID_HI = 6'h01;
  localparam logic [AW-1:0] A_PID_LO = 6'h02;
  localparam logic [AW-1:0] A_PID_HI = 6'h03;
  localparam logic [AW-1:0] A_ISTAT = 6'h13;
  localparam logic [AW-1:0] A_ILATCH = 6'h14;
  localparam logic [AW-1:0] A_DEBUG = 6'h15;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_SET   = 2'd1,
    ACC_CLEAR = 2'd2,
    ACC_NONE  = 2'd3
  } acc_kind_e;

  function automatic logic [AW-1:0] ctrl_base(int i);
    case (i)
      CI_FUNC:    return 6'h04;
      CI_INTF:    return 6'h07;
      CI_OTG:     return 6'h0A;
      CI_IE_RISE: return 6'h0D;
      CI_IE_FALL: return 6'h10;
      default:    return 6'h3D;
    endcase
  endfunction

  function automatic logic [DW-1:0] ctrl_mask(int i);
    case (i)
      CI_FUNC:    return 8'h7F;
      CI_INTF:    return 8'hFF;
      CI_OTG:     return 8'hFF;
      CI_IE_RISE: return 8'h1F;
      CI_IE_FALL: return 8'h1F;
      default:    return 8'h07;
    endcase
  endfunction

  function automatic logic [DW-1:0] ctrl_reset(int i);
    case (i)
      CI_FUNC:    return 8'h41;
      CI_OTG:     return 8'h06;
      CI_IE_RISE: return 8'h1F;
      CI_IE_FALL: return 8'h1F;
      default:    return 8'h00;
    endcase
  endfunction

  function automatic logic [DW-1:0] alias_next(acc_kind_e k, logic [DW-1:0] q,
                                               logic [DW-1:0] d, logic [DW-1:0] m);
    case (k)
      ACC_LOAD:  return d & m;
      ACC_SET:   return q | (d & m);
      ACC_CLEAR: return q & ~d;
      default:   return q;
    endcase
  endfunction
endpackage

// File: rtl/ulpi_rf_alias_reg.sv
module ulpi_rf_alias_reg
  import ulpi_rf_pkg::*;
#(
  parameter logic [AW-1:0] BASE  = 6'h04,
  parameter logic [DW-1:0] MASK  = 8'hFF,
  parameter logic [DW-1:0] RESET = 8'h00
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic          hit,
  output logic [DW-1:0] q
);
  logic [AW-1:0] offset;
  acc_kind_e     kind;

  assign offset = addr - BASE;
  assign hit    = (offset < AW'(ALIAS_N));
  assign kind   = hit ? acc_kind_e'(offset[1:0]) : ACC_NONE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q <= RESET & MASK;
    end else if (wr_en && hit) begin
      q <= alias_next(kind, q, wr_data, MASK);
    end
  end
endmodule

// File: rtl/ulpi_rf_irq.sv
module ulpi_rf_irq #(
  parameter int NSRC = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_in,
  input  logic [NSRC-1:0] en_rise,
  input  logic [NSRC-1:0] en_fall,
  input  logic            clr,
  output logic [NSRC-1:0] status,
  output logic [NSRC-1:0] latch
);
  logic [NSRC-1:0] src_q, src_d;
  logic            primed;
  logic [NSRC-1:0] ev_rise, ev_fall;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      primed <= 1'b0;
      src_q  <= '0;
      src_d  <= '0;
    end else begin
      primed <= 1'b1;
      src_q  <= src_in;
      src_d  <= primed ? src_q : src_in;
    end
  end

  assign ev_rise = src_q & ~src_d & en_rise;
  assign ev_fall = ~src_q & src_d & en_fall;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latch <= '0;
    end else begin
      latch <= (clr ? '0 : latch) | ev_rise | ev_fall;
    end
  end

  assign status = src_q;
endmodule

// File: rtl/ulpi_rf_rdmux.sv
module ulpi_rf_rdmux
  import ulpi_rf_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID  = 16'h0000,
  parameter logic [15:0] PRODUCT_ID = 16'h0000,
  parameter int          NSRC       = 5,
  parameter int          LS_W       = 2
) (
  input  logic [AW-1:0]                addr,
  input  logic                         rd_en,
  input  logic [NUM_CTRL-1:0]          hit,
  input  logic [NUM_CTRL-1:0][DW-1:0]  ctrl,
  input  logic [NSRC-1:0]              status,
  input  logic [NSRC-1:0]              latch,
  input  logic [LS_W-1:0]              line_state,
  output logic [DW-1:0]                rd_data
);
  logic [DW-1:0] sel;

  always_comb begin
    sel = '0;
    case (addr)
      A_VID_LO: sel = VENDOR_ID[7:0];
      A_VID_HI: sel = VENDOR_ID[15:8];
      A_PID_LO: sel = PRODUCT_ID[7:0];
      A_PID_HI: sel = PRODUCT_ID[15:8];
      A_ISTAT:  sel = DW'(status);
      A_ILATCH: sel = DW'(latch);
      A_DEBUG:  sel = DW'(line_state);
      default: begin
        for (int i = 0; i < NUM_CTRL; i++) begin
          if (hit[i]) sel = ctrl[i];
        end
      end
    endcase
    rd_data = rd_en ? sel : '0;
  end
endmodule

// File: rtl/ulpi_phy_regfile.sv
module ulpi_phy_regfile
  import ulpi_rf_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID  = 16'h1A2B,
  parameter logic [15:0] PRODUCT_ID = 16'h3C5D,
  parameter int          NUM_SRC    = 5,
  parameter int          LS_W       = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [AW-1:0]      reg_addr,
  input  logic               reg_wr,
  input  logic [DW-1:0]      reg_wdata,
  input  logic               reg_rd,
  output logic [DW-1:0]      reg_rdata,
  input  logic [NUM_SRC-1:0] irq_src,
  input  logic [LS_W-1:0]    line_state,
  output logic [DW-1:0]      func_ctrl,
  output logic [DW-1:0]      intf_ctrl,
  output logic [DW-1:0]      otg_ctrl,
  output logic [DW-1:0]      pwr_ctrl,
  output logic               irq
);
  logic [NUM_CTRL-1:0][DW-1:0] ctrl_q;
  logic [NUM_CTRL-1:0]         ctrl_hit;
  logic [NUM_SRC-1:0]          src_status, src_latch;
  logic                        latch_clr;

  for (genvar g = 0; g < NUM_CTRL; g++) begin : g_ctrl
    ulpi_rf_alias_reg #(
      .BASE (ctrl_base(g)),
      .MASK (ctrl_mask(g)),
      .RESET(ctrl_reset(g))
    ) u_reg (
      .clk    (clk),
      .rst_n  (rst_n),
      .addr   (reg_addr),
      .wr_en  (reg_wr),
      .wr_data(reg_wdata),
      .hit    (ctrl_hit[g]),
      .q      (ctrl_q[g])
    );
  end

  assign latch_clr = reg_rd && (reg_addr == A_ILATCH);

  ulpi_rf_irq #(.NSRC(NUM_SRC)) u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .src_in (irq_src),
    .en_rise(ctrl_q[CI_IE_RISE][NUM_SRC-1:0]),
    .en_fall(ctrl_q[CI_IE_FALL][NUM_SRC-1:0]),
    .clr    (latch_clr),
    .status (src_status),
    .latch  (src_latch)
  );

  ulpi_rf_rdmux #(
    .VENDOR_ID (VENDOR_ID),
    .PRODUCT_ID(PRODUCT_ID),
    .NSRC      (NUM_SRC),
    .LS_W      (LS_W)
  ) u_rdmux (
    .addr      (reg_addr),
    .rd_en     (reg_rd),
    .hit       (ctrl_hit),
    .ctrl      (ctrl_q),
    .status    (src_status),
    .latch     (src_latch),
    .line_state(line_state),
    .rd_data   (reg_rdata)
  );

  assign func_ctrl = ctrl_q[CI_FUNC];
  assign intf_ctrl = ctrl_q[CI_INTF];
  assign otg_ctrl  = ctrl_q[CI_OTG];
  assign pwr_ctrl  = ctrl_q[CI_PWR];
  assign irq       = |src_latch;
endmodule

// File: rtl/ulpi_phy_regfile_chk.sv
module ulpi_phy_regfile_chk
  import ulpi_rf_pkg::*;
#(
  parameter int NUM_SRC = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic [AW-1:0]      reg_addr,
  input logic               reg_wr,
  input logic [DW-1:0]      reg_wdata,
  input logic               reg_rd,
  input logic [DW-1:0]      reg_rdata,
  input logic [NUM_SRC-1:0] irq_src,
  input logic [DW-1:0]      func_ctrl,
  input logic [DW-1:0]      otg_ctrl,
  input logic [DW-1:0]      pwr_ctrl,
  input logic               irq
);
  assert_load_func_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 6'h04) |=> (func_ctrl == ($past(reg_wdata) & 8'h7F)));

  assert_set_pwr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 6'h3E) |=>
      (pwr_ctrl == ($past(pwr_ctrl) | ($past(reg_wdata) & 8'h07))));

  assert_clear_otg_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 6'h0C) |=> (otg_ctrl == ($past(otg_ctrl) & ~$past(reg_wdata))));

  assert_reserved_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (func_ctrl[7] == 1'b0) && (pwr_ctrl[7:3] == 5'd0));

  assert_irq_needs_change_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(irq_src, 2) != $past(irq_src, 3)));

  assert_latch_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(reg_rd && reg_addr == A_ILATCH)) |=> irq);

  assert_unmapped_zero_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr > 6'h15 && reg_addr < 6'h3D) |-> (reg_rdata == 8'h00));

  assert_idle_rdata_R14: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |-> (reg_rdata == 8'h00));
endmodule

bind ulpi_phy_regfile ulpi_phy_regfile_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_addr (reg_addr),
  .reg_wr   (reg_wr),
  .reg_wdata(reg_wdata),
  .reg_rd   (reg_rd),
  .reg_rdata(reg_rdata),
  .irq_src  (irq_src),
  .func_ctrl(func_ctrl),
  .otg_ctrl (otg_ctrl),
  .pwr_ctrl (pwr_ctrl),
  .irq      (irq)
);

// File: tb/ulpi_phy_regfile_tb.sv
module ulpi_phy_regfile_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] VID = 16'hA5C3;
  localparam logic [15:0] PID = 16'h0E71;
  localparam logic [5:0] BASES [6] = '{6'h04, 6'h07, 6'h0A, 6'h0D, 6'h10, 6'h3D};
  localparam logic [7:0] MASKS [6] = '{8'h7F, 8'hFF, 8'hFF, 8'h1F, 8'h1F, 8'h07};
  localparam logic [7:0] RSTV  [6] = '{8'h41, 8'h00, 8'h06, 8'h1F, 8'h1F, 8'h00};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic       reg_rd = 1'b0;
  logic [7:0] reg_rdata;
  logic [4:0] irq_src = '0;
  logic [1:0] line_state = 2'b10;
  logic [7:0] func_ctrl, intf_ctrl, otg_ctrl, pwr_ctrl;
  logic       irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [7:0] m [6];

  always #(CLK_PERIOD / 2) clk = ~clk;

  ulpi_phy_regfile #(.VENDOR_ID(VID), .PRODUCT_ID(PID), .NUM_SRC(5), .LS_W(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rd(reg_rd), .reg_rdata(reg_rdata), .irq_src(irq_src), .line_state(line_state),
    .func_ctrl(func_ctrl), .intf_ctrl(intf_ctrl), .otg_ctrl(otg_ctrl), .pwr_ctrl(pwr_ctrl),
    .irq(irq));

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic [5:0] a, input logic w, input logic r, input logic [7:0] d,
                     output logic [7:0] rd);
    @(negedge clk);
    reg_addr = a; reg_wr = w; reg_rd = r; reg_wdata = d;
    #1 rd = reg_rdata;
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    logic [7:0] x;
    cyc(a, 1'b1, 1'b0, d, x);
  endtask

  task automatic rd_chk(string req, input logic [5:0] a, input logic [7:0] exp);
    logic [7:0] x;
    cyc(a, 1'b0, 1'b1, 8'h00, x);
    check(req, x, exp);
  endtask

  task automatic idle();
    logic [7:0] x;
    cyc(6'h00, 1'b0, 1'b0, 8'h00, x);
  endtask

  function automatic void mwrite(logic [5:0] a, logic [7:0] d);
    for (int i = 0; i < 6; i++) begin
      logic [5:0] off = a - BASES[i];
      if (off == 6'd0) m[i] = d & MASKS[i];
      else if (off == 6'd1) m[i] = m[i] | (d & MASKS[i]);
      else if (off == 6'd2) m[i] = m[i] & ~d;
    end
  endfunction

  function automatic logic [7:0] mread(logic [5:0] a);
    case (a)
      6'h00: return VID[7:0];
      6'h01: return VID[15:8];
      6'h02: return PID[7:0];
      6'h03: return PID[15:8];
      6'h13, 6'h14: return 8'h00;
      6'h15: return {6'b0, line_state};
      default: begin
        for (int i = 0; i < 6; i++) begin
          logic [5:0] off = a - BASES[i];
          if (off < 6'd3) return m[i];
        end
        return 8'h00;
      end
    endcase
  endfunction

  function automatic string req_of(logic [5:0] a);
    if (a < 6'h04) return "R1";
    if (a > 6'h15 && a < 6'h3D) return "R13";
    if (a >= 6'h13 && a <= 6'h15) return "R8";
    return "R6";
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] x;
    void'($urandom(32'h5EED));
    for (int i = 0; i < 6; i++) m[i] = RSTV[i];
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R2 func reset", func_ctrl, 8'h41);
    check("R2 otg reset", otg_ctrl, 8'h06);
    check("R2 irq reset", {7'b0, irq}, 8'h00);
    rst_n = 1'b1;

    for (int i = 0; i < 6; i++) rd_chk("R2 reset read", BASES[i], RSTV[i]);
    rd_chk("R1 vid lo", 6'h00, VID[7:0]);
    rd_chk("R1 pid hi", 6'h03, PID[15:8]);
    wr(6'h01, 8'h00);
    rd_chk("R1 write ignored", 6'h01, VID[15:8]);
    cyc(6'h04, 1'b0, 1'b0, 8'h00, x);
    check("R14 no read", x, 8'h00);

    wr(6'h04, 8'hFF); mwrite(6'h04, 8'hFF);
    rd_chk("R7 func bit7", 6'h06, 8'h7F);
    wr(6'h3D, 8'hFF); mwrite(6'h3D, 8'hFF);
    idle();
    check("R7 pwr reserved", pwr_ctrl, 8'h07);
    wr(6'h0E, 8'hE0); mwrite(6'h0E, 8'hE0);
    rd_chk("R7 enable reserved", 6'h0D, 8'h1F);
    wr(6'h0C, 8'h04); mwrite(6'h0C, 8'h04);
    rd_chk("R5 clear alias", 6'h0B, 8'h02);
    wr(6'h08, 8'h81); mwrite(6'h08, 8'h81);
    rd_chk("R4 set alias", 6'h09, 8'h81);
    wr(6'h20, 8'hFF);
    rd_chk("R13 unmapped read", 6'h20, 8'h00);
    rd_chk("R13 write ignored", 6'h07, 8'h81);
    rd_chk("R8 debug", 6'h15, 8'h02);
    line_state = 2'b01;
    rd_chk("R8 debug live", 6'h15, 8'h01);

    for (int it = 0; it < 400; it++) begin
      logic [5:0] a;
      int r = $urandom % 25;
      int op = $urandom % 3;
      logic [7:0] d = 8'($urandom);
      if ($urandom % 2) a = (r < 22) ? 6'(r) : 6'(6'h3D + r - 22);
      else a = 6'($urandom % 64);
      if (op == 0) begin
        wr(a, d); mwrite(a, d);
        idle();
        check("R3 func out", func_ctrl, m[0]);
        check("R3 intf out", intf_ctrl, m[1]);
        check("R3 otg out", otg_ctrl, m[2]);
        check("R7 pwr out", pwr_ctrl, m[5]);
      end else if (op == 1) begin
        rd_chk(req_of(a), a, mread(a));
      end else begin
        idle();
      end
    end

    wr(6'h0D, 8'h1F);
    wr(6'h10, 8'h00);
    irq_src = 5'h10;
    idle(); idle();
    check("R12 irq set", {7'b0, irq}, 8'h01);
    rd_chk("R8 status", 6'h13, 8'h10);
    rd_chk("R9 rise latch", 6'h14, 8'h10);
    idle();
    check("R12 irq cleared", {7'b0, irq}, 8'h00);
    rd_chk("R11 cleared on read", 6'h14, 8'h00);

    irq_src = 5'h00;
    idle(); idle();
    rd_chk("R10 fall disabled", 6'h14, 8'h00);

    wr(6'h11, 8'h10);
    irq_src = 5'h10;
    idle(); idle();
    rd_chk("R9 rise again", 6'h14, 8'h10);
    irq_src = 5'h00;
    idle(); idle();
    rd_chk("R10 fall latch", 6'h14, 8'h10);

    irq_src = 5'h10;
    rd_chk("R11 read before set", 6'h14, 8'h00);
    rd_chk("R11 set beats clear", 6'h14, 8'h10);

    wr(6'h0F, 8'h10);
    rd_chk("R5 rise enable clear", 6'h0D, 8'h0F);
    irq_src = 5'h00;
    idle(); idle();
    rd_chk("R10 fall only", 6'h14, 8'h10);
    irq_src = 5'h10;
    idle(); idle();
    rd_chk("R9 rise disabled", 6'h14, 8'h00);

    wr(6'h0E, 8'h10);
    irq_src = 5'h13;
    idle(); idle();
    rd_chk("R9 multi bit", 6'h14, 8'h03);
    rd_chk("R8 status multi", 6'h13, 8'h13);

    idle();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule